// File: doc/BRIEF.md
# Circular Audio Sample Fetcher

This block drains a ring of stereo audio samples held in shared memory at a fixed rate. Each ring entry is one 32-bit word carrying a left and a right 16-bit sample. Once per programmed sample period, counted in clock cycles, the block issues one read request for the entry under its tail pointer. It then steps the pointer by one word. After the inclusive last location it returns the pointer to the first location. Returned words appear on a sample output with a one-cycle valid strobe, ready for a serializer or a DAC feeder.

A producer fills the ring ahead of the tail. It can poll the tail pointer at any time, or it can rely on two optional one-cycle event pulses. One pulse fires when the reader leaves the last entry (wrap). The other fires when the reader reaches the middle of the ring (half). Together they allow ping-pong filling of the two halves. A period of zero stops all sample traffic, while the enable and pointer logic stay in their normal state.

The start, last, period and event-mask settings are captured only while the block is disabled. Raising the enable restarts the tail at the start address. If a read has not returned by the next period tick, that tick is a miss. The block then re-emits the previous sample and flags the miss instead of queueing a second read.

Top module: `audio_ring_reader`

## Requirements
- R1: While reset is asserted, mem_req, smp_valid, evt_wrap, evt_half and tick_missed are 0 and tail_ptr is 0.
- R2: While the enable has been low for at least one cycle, no request is issued, smp_valid stays 0, and tail_ptr shows the cfg_start value of the previous clock edge.
- R3: With a nonzero period P, period ticks fall every P cycles. The first tick comes P cycles after the first clock edge that sees the enable high. A tick with no read outstanding drives mem_req high for exactly that cycle.
- R4: Request addresses follow start, start+4, start+8, ..., last, then start again. last is the inclusive final entry and lies a multiple of 4 above start.
- R5: With bit 0 of cfg_evt_mask set, evt_wrap pulses in the same cycle as the request whose address is the last entry.
- R6: With bit 1 of cfg_evt_mask set, evt_half pulses in the same cycle as the request that moves the tail onto the midpoint. The midpoint is start + 4*floor(N/2), with N = (last-start)/4 + 1 entries. The pulse comes once per pass through the ring and never when N = 1.
- R7: An event whose mask bit is clear never pulses.
- R8: One cycle after mem_rvalid is high while enabled, smp_valid is high and smp_data equals the returned mem_rdata.
- R9: A tick that finds a read still outstanding issues no request and leaves tail_ptr unchanged. In that cycle it raises tick_missed and smp_valid, and smp_data repeats the last sample delivered.
- R10: A zero period produces no requests, no misses and no samples, and tail_ptr stays at start.
- R11: Changes to cfg_start, cfg_last, cfg_period and cfg_evt_mask while enabled have no effect on the request timing, addresses or events of the current run.
- R12: tail_ptr always shows the address of the next read. While enabled it changes only in the cycle a request appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; configuration is captured while low |
| cfg_start | input | ADDR_W | Byte address of the first ring entry |
| cfg_last | input | ADDR_W | Byte address of the last ring entry (inclusive) |
| cfg_period | input | PER_W | Sample period in clock cycles; 0 disables samples |
| cfg_evt_mask | input | 2 | Bit 0 enables the wrap event, bit 1 the half event |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Read address, valid with mem_req |
| mem_rvalid | input | 1 | Read data return strobe |
| mem_rdata | input | DATA_W | Returned ring entry |
| smp_data | output | DATA_W | Current stereo sample |
| smp_valid | output | 1 | One-cycle strobe for a new or repeated sample |
| tail_ptr | output | ADDR_W | Address of the next entry to be read |
| evt_wrap | output | 1 | Pulse as the last entry is requested |
| evt_half | output | 1 | Pulse as the tail reaches the midpoint |
| tick_missed | output | 1 | Pulse when a tick found a read outstanding |

## Verification
Directed runs cover the ring sizes that stress the pointer arithmetic. A one-entry ring and a two-entry ring show whether the wrap and midpoint compares are kept apart. An odd-sized ring checks the rounding of the midpoint. A masked run shows that events are truly gated. Memory latencies longer than the period, and a one-cycle period, force the miss path and separate a repeat of the held sample from a stall or a skipped pointer step. Random rings, periods, masks and latencies, with the configuration inputs scribbled while enabled, show whether settings leak into a live run. A zero period confirms that the pointer stays parked.

// File: rtl/audio_ring_pkg.sv
package audio_ring_pkg;

   // bit positions inside the event mask
   localparam int EVT_WRAP_BIT = 0;
   localparam int EVT_HALF_BIT = 1;
   localparam int EVT_COUNT    = 2;

   // read tracking state
   typedef enum logic {
      FETCH_IDLE = 1'b0,
      FETCH_WAIT = 1'b1
   } fetch_state_t;

endpackage

// File: rtl/audio_ring_cfg.sv
module audio_ring_cfg
   import audio_ring_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int PER_W   = 16,
   parameter int STEP_SH = 2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frozen,
   input  logic [ADDR_W-1:0]    cfg_start,
   input  logic [ADDR_W-1:0]    cfg_last,
   input  logic [PER_W-1:0]     cfg_period,
   input  logic [EVT_COUNT-1:0] cfg_evt_mask,
   output logic [ADDR_W-1:0]    start_q,
   output logic [ADDR_W-1:0]    last_q,
   output logic [ADDR_W-1:0]    mid_q,
   output logic [PER_W-1:0]     period_q,
   output logic [EVT_COUNT-1:0] mask_q
);

   logic [ADDR_W-1:0] span;
   logic [ADDR_W-1:0] entries;
   logic [ADDR_W-1:0] half_entries;
   logic [ADDR_W-1:0] mid_next;

   always_comb begin
      span         = cfg_last - cfg_start;
      entries      = (span >> STEP_SH) + ADDR_W'(1);
      half_entries = entries >> 1;
      mid_next     = cfg_start + (half_entries << STEP_SH);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q  <= '0;
         last_q   <= '0;
         mid_q    <= '0;
         period_q <= '0;
         mask_q   <= '0;
      end else if (!frozen) begin
         start_q  <= cfg_start;
         last_q   <= cfg_last;
         mid_q    <= mid_next;
         period_q <= cfg_period;
         mask_q   <= cfg_evt_mask;
      end
   end

endmodule

// File: rtl/audio_ring_pacer.sv
module audio_ring_pacer #(
   parameter int PER_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PER_W-1:0] period,
   output logic             tick
);

   logic [PER_W-1:0] cnt;
   logic             live;

   assign live = run && (period != '0);
   assign tick = live && (cnt == period - PER_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (!live) cnt <= '0;
      else if (tick)  cnt <= '0;
      else            cnt <= cnt + PER_W'(1);
   end

endmodule

// File: rtl/audio_ring_walker.sv
module audio_ring_walker #(
   parameter int ADDR_W   = 16,
   parameter int STEP_SH  = 2,
   parameter bit HALF_EVT = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   input  logic [ADDR_W-1:0] start,
   input  logic [ADDR_W-1:0] last,
   input  logic [ADDR_W-1:0] mid,
   output logic [ADDR_W-1:0] ptr,
   output logic              at_last,
   output logic              half_next
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << STEP_SH;

   logic [ADDR_W-1:0] ptr_inc;

   assign ptr_inc = ptr + STEP;
   assign at_last = (ptr == last);

   generate
      if (HALF_EVT) begin : g_half
         assign half_next = !at_last && (ptr_inc == mid);
      end else begin : g_no_half
         assign half_next = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       ptr <= '0;
      else if (load)    ptr <= load_addr;
      else if (step)    ptr <= at_last ? start : ptr_inc;
   end

endmodule

// File: rtl/audio_ring_reader.sv
module audio_ring_reader
   import audio_ring_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 32,
   parameter int PER_W    = 16,
   parameter bit HALF_EVT = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic [ADDR_W-1:0]    cfg_start,
   input  logic [ADDR_W-1:0]    cfg_last,
   input  logic [PER_W-1:0]     cfg_period,
   input  logic [EVT_COUNT-1:0] cfg_evt_mask,
   output logic                 mem_req,
   output logic [ADDR_W-1:0]    mem_addr,
   input  logic                 mem_rvalid,
   input  logic [DATA_W-1:0]    mem_rdata,
   output logic [DATA_W-1:0]    smp_data,
   output logic                 smp_valid,
   output logic [ADDR_W-1:0]    tail_ptr,
   output logic                 evt_wrap,
   output logic                 evt_half,
   output logic                 tick_missed
);

   localparam int BYTES   = DATA_W / 8;
   localparam int STEP_SH = $clog2(BYTES);

   generate
      if ((DATA_W % 8) != 0 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_data_w
         $error("DATA_W must be a power-of-two number of bytes");
      end
      if (ADDR_W <= STEP_SH + 1) begin : g_bad_addr_w
         $error("ADDR_W too small for the entry size");
      end
      if (PER_W < 1) begin : g_bad_per_w
         $error("PER_W must be at least 1");
      end
   endgenerate

   logic                 en_q;
   logic [ADDR_W-1:0]    start_q, last_q, mid_q;
   logic [PER_W-1:0]     period_q;
   logic [EVT_COUNT-1:0] mask_q;
   logic                 tick;
   logic [ADDR_W-1:0]    ptr;
   logic                 at_last, half_next;
   fetch_state_t         fstate;
   logic                 busy, issue, miss;

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en;
   end

   audio_ring_cfg #(
      .ADDR_W (ADDR_W),
      .PER_W  (PER_W),
      .STEP_SH(STEP_SH)
   ) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .frozen      (en_q),
      .cfg_start   (cfg_start),
      .cfg_last    (cfg_last),
      .cfg_period  (cfg_period),
      .cfg_evt_mask(cfg_evt_mask),
      .start_q     (start_q),
      .last_q      (last_q),
      .mid_q       (mid_q),
      .period_q    (period_q),
      .mask_q      (mask_q)
   );

   audio_ring_pacer #(
      .PER_W(PER_W)
   ) u_pacer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (en_q),
      .period(period_q),
      .tick  (tick)
   );

   audio_ring_walker #(
      .ADDR_W  (ADDR_W),
      .STEP_SH (STEP_SH),
      .HALF_EVT(HALF_EVT)
   ) u_walker (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (!en_q),
      .load_addr(cfg_start),
      .step     (issue),
      .start    (start_q),
      .last     (last_q),
      .mid      (mid_q),
      .ptr      (ptr),
      .at_last  (at_last),
      .half_next(half_next)
   );

   // a response arriving at the tick edge frees the slot for a new read
   assign busy  = (fstate == FETCH_WAIT) && !mem_rvalid;
   assign issue = tick && !busy;
   assign miss  = tick && busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fstate      <= FETCH_IDLE;
         mem_req     <= 1'b0;
         mem_addr    <= '0;
         smp_data    <= '0;
         smp_valid   <= 1'b0;
         evt_wrap    <= 1'b0;
         evt_half    <= 1'b0;
         tick_missed <= 1'b0;
      end else if (!en_q) begin
         fstate      <= FETCH_IDLE;
         mem_req     <= 1'b0;
         smp_valid   <= 1'b0;
         evt_wrap    <= 1'b0;
         evt_half    <= 1'b0;
         tick_missed <= 1'b0;
      end else begin
         mem_req     <= issue;
         evt_wrap    <= issue && at_last   && mask_q[EVT_WRAP_BIT];
         evt_half    <= issue && half_next && mask_q[EVT_HALF_BIT];
         tick_missed <= miss;
         smp_valid   <= mem_rvalid || miss;
         if (issue)      mem_addr <= ptr;
         if (mem_rvalid) smp_data <= mem_rdata;
         if (issue)           fstate <= FETCH_WAIT;
         else if (mem_rvalid) fstate <= FETCH_IDLE;
      end
   end

   assign tail_ptr = ptr;

endmodule

// File: rtl/audio_ring_checker.sv
module audio_ring_checker #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              mem_req,
   input logic              mem_rvalid,
   input logic [DATA_W-1:0] mem_rdata,
   input logic [DATA_W-1:0] smp_data,
   input logic              smp_valid,
   input logic [ADDR_W-1:0] tail_ptr,
   input logic              evt_wrap,
   input logic              evt_half,
   input logic              tick_missed
);

   // R2: two cycles of low enable leave no request
   p_idle_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en, 2) |-> !mem_req);

   // R5: wrap event only with a request
   p_wrap_with_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_wrap |-> mem_req);

   // R6: half event only with a request, never together with wrap
   p_half_with_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_half |-> mem_req);
   p_evt_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({evt_wrap, evt_half}));

   // R8: a response becomes the next sample
   p_resp_to_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && mem_rvalid) |=> (smp_valid && smp_data == $past(mem_rdata)));

   // R9: a miss repeats the held sample and issues nothing
   p_miss_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tick_missed |-> (!mem_req && smp_valid && $stable(smp_data) && $stable(tail_ptr)));

   // R12: while running the tail moves only with a request
   p_tail_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && $past(en, 2) && !mem_req) |-> $stable(tail_ptr));

endmodule

bind audio_ring_reader audio_ring_checker #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (en),
   .mem_req    (mem_req),
   .mem_rvalid (mem_rvalid),
   .mem_rdata  (mem_rdata),
   .smp_data   (smp_data),
   .smp_valid  (smp_valid),
   .tail_ptr   (tail_ptr),
   .evt_wrap   (evt_wrap),
   .evt_half   (evt_half),
   .tick_missed(tick_missed)
);

// File: tb/sim_audio_ring_reader.sv
module sim_audio_ring_reader;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int PW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic [AW-1:0] cfg_start = '0, cfg_last = '0;
   logic [PW-1:0] cfg_period = '0;
   logic [1:0]    cfg_evt_mask = '0;
   logic          mem_req, mem_rvalid;
   logic [AW-1:0] mem_addr, tail_ptr;
   logic [DW-1:0] mem_rdata, smp_data;
   logic          smp_valid, evt_wrap, evt_half, tick_missed;

   int checks = 0;
   int errors = 0;
   int lat = 1;
   bit scrib = 0;

   audio_ring_reader #(.ADDR_W(AW), .DATA_W(DW), .PER_W(PW)) u0 (
      .clk(clk), .rst_n(rst_n), .en(en),
      .cfg_start(cfg_start), .cfg_last(cfg_last), .cfg_period(cfg_period),
      .cfg_evt_mask(cfg_evt_mask),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .smp_data(smp_data), .smp_valid(smp_valid),
      .tail_ptr(tail_ptr), .evt_wrap(evt_wrap), .evt_half(evt_half),
      .tick_missed(tick_missed)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [DW-1:0] data_of(logic [AW-1:0] a);
      return {~a, a};
   endfunction

   // memory model with a fixed latency of lat cycles
   logic [7:0]    pv;
   logic [AW-1:0] pa [8];
   always @(posedge clk) begin
      if (!rst_n) pv <= '0;
      else        pv <= {pv[6:0], mem_req};
      pa[0] <= mem_addr;
      for (int i = 1; i < 8; i++) pa[i] <= pa[i-1];
   end
   assign mem_rvalid = pv[lat-1];
   assign mem_rdata  = data_of(pa[lat-1]);

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference state
   bit            prev_en = 0, active = 0, outst = 0, prev_rv = 0;
   logic [DW-1:0] prev_rd, last_data;
   logic [AW-1:0] e_start, e_last, e_mid, e_addr;
   logic [PW-1:0] e_per;
   logic [1:0]    e_mask;
   int            cyc;

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_en = 0; active = 0; prev_rv = 0; outst = 0;
      end else begin
         if (en && !prev_en) begin
            active = 1; cyc = 0; outst = 0;
            e_start = cfg_start; e_last = cfg_last; e_per = cfg_period; e_mask = cfg_evt_mask;
            e_mid = cfg_start + AW'((((cfg_last - cfg_start) >> 2) + 1) >> 1) * AW'(4);
            e_addr = cfg_start;
            last_data = smp_data;
            chk(tail_ptr == e_start, "R12 tail at enable", tail_ptr, e_start);
         end else if (en && active) begin
            bit tick, miss_e, req_e, exp_v, w_e, h_e;
            logic [DW-1:0] exp_d;
            cyc++;
            tick   = (e_per != 0) && (cyc % e_per == 0);
            miss_e = tick && outst;
            req_e  = tick && !outst;
            chk(mem_req == req_e, (e_per == 0) ? "R10 request" : "R3 request", mem_req, req_e);
            chk(tick_missed == miss_e, "R9 miss flag", tick_missed, miss_e);
            if (req_e && mem_req) begin
               w_e = e_mask[0] && (e_addr == e_last);
               h_e = e_mask[1] && (e_addr != e_last) && (e_addr + AW'(4) == e_mid);
               chk(mem_addr == e_addr, scrib ? "R11 address" : "R4 address", mem_addr, e_addr);
               chk(evt_wrap == w_e, e_mask[0] ? "R5 wrap" : "R7 wrap masked", evt_wrap, w_e);
               chk(evt_half == h_e, e_mask[1] ? "R6 half" : "R7 half masked", evt_half, h_e);
               e_addr = (e_addr == e_last) ? e_start : e_addr + AW'(4);
            end else begin
               chk(!evt_wrap && !evt_half, "R7 no event", {evt_wrap, evt_half}, 0);
            end
            chk(tail_ptr == e_addr, (e_per == 0) ? "R10 tail" : "R12 tail", tail_ptr, e_addr);
            exp_v = prev_rv || miss_e;
            chk(smp_valid == exp_v, miss_e ? "R9 valid" : "R8 valid", smp_valid, exp_v);
            if (exp_v) begin
               exp_d = prev_rv ? prev_rd : last_data;
               chk(smp_data == exp_d, miss_e ? "R9 repeat data" : "R8 data", smp_data, exp_d);
               last_data = exp_d;
            end
            if (mem_rvalid) outst = 0;
            if (mem_req)    outst = 1;
         end else if (!en && prev_en) begin
            active = 0;
         end else if (!en && !prev_en) begin
            chk(mem_req == 0, "R2 no request", mem_req, 0);
            chk(smp_valid == 0, "R2 no sample", smp_valid, 0);
            chk(tail_ptr == cfg_start, "R2 tail follows start", tail_ptr, cfg_start);
         end
         prev_rv = mem_rvalid;
         prev_rd = mem_rdata;
         prev_en = en;
      end
   end

   task automatic run_cfg(input int start, input int n, input int per, input int mask,
                          input int lat_v, input int cycles, input bit scr);
      @(negedge clk); #1; en = 0;
      repeat (12) @(negedge clk);
      #1;
      cfg_start = AW'(start); cfg_last = AW'(start + 4*(n-1));
      cfg_period = PW'(per); cfg_evt_mask = 2'(mask); lat = lat_v; scrib = scr;
      repeat (3) @(negedge clk);
      #1; en = 1;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk); #1;
         if (scr && ($urandom % 4 == 0)) begin
            cfg_start = AW'($urandom); cfg_last = AW'($urandom);
            cfg_period = PW'($urandom % 5); cfg_evt_mask = 2'($urandom);
         end
      end
      en = 0;
      repeat (12) @(negedge clk);
      scrib = 0;
   endtask

   initial begin
      void'($urandom(32'h5EED_0A17));
      repeat (3) @(negedge clk);
      // R1: outputs idle in reset
      chk(!mem_req && !smp_valid && !evt_wrap && !evt_half && !tick_missed,
          "R1 idle outputs", {mem_req, smp_valid, evt_wrap, evt_half, tick_missed}, 0);
      chk(tail_ptr == 0, "R1 tail", tail_ptr, 0);
      #1; rst_n = 1;
      // directed corners
      run_cfg(16'h0100, 1, 3, 3, 1, 40, 0);   // single entry: wrap each request, no half
      run_cfg(16'h0200, 2, 4, 3, 2, 60, 0);   // two entries
      run_cfg(16'h0300, 5, 3, 3, 1, 80, 0);   // odd ring, midpoint rounding
      run_cfg(16'h0400, 6, 4, 0, 1, 80, 0);   // events masked
      run_cfg(16'h0500, 4, 0, 3, 1, 40, 0);   // zero period
      run_cfg(16'h0600, 4, 1, 3, 1, 40, 0);   // one-cycle period, misses
      run_cfg(16'h0700, 8, 3, 2, 5, 90, 0);   // latency beyond period
      // random runs with live configuration scribbling
      for (int r = 0; r < 16; r++) begin
         int n = 1 + ($urandom % 12);
         int st = 4 * ($urandom % 4000);
         int per = 1 + ($urandom % 8);
         int lv = 1 + ($urandom % 6);
         run_cfg(st, n, per, $urandom % 4, lv, 60 + n * per * 3, 1'($urandom % 2));
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule